// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block handles interrupts for a small 8-bit microcontroller core. It has two sources: an active-low external interrupt pin and a one-cycle overflow strobe from timer 0. Each source sets its own request flag in a single control register. That register also holds a master enable and one enable bit per source. Software reads and writes the register through a simple data-space port.

When a flag is set, its source is enabled, the master enable is on and the core reports that the return stack has room, the block accepts the interrupt. It then pulses a call request to the core with the source's vector address and a one-hot source code. On that same clock edge it clears the master enable, so a second interrupt cannot nest, and it clears the serviced flag. Other flags keep latching, so those requests are served later. The core saves only the program counter; the status register is not pushed, so software must save it. Software may set the master enable again inside a service routine to allow nesting.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `call_req` is 0, `call_vec` is 0x00 and `call_src` is 0.
- R2: The control register sits at address 0x0B. Bit 0 is the master enable, bit 1 the external enable, bit 2 the timer enable, bit 4 the external flag and bit 5 the timer flag. All five bits are writable. Bits 3, 6 and 7 read 0. Reads of any other address return 0x00, and writes to any other address leave the register unchanged.
- R3: `int_n` passes through a two-flop synchronizer. A high-to-low transition on it sets bit 4 on the third rising clock edge after the pin changes. A rising transition or a steady level sets nothing.
- R4: A high `tmr_ovf` sets bit 5 on the next rising clock edge.
- R5: An accepted interrupt makes `call_req` high for exactly one cycle, on the edge after the acceptance condition holds. It gives vector 0x04 with `call_src`=2'b01 for the external source, and vector 0x08 with `call_src`=2'b10 for the timer.
- R6: Acceptance clears the master enable and the serviced flag on the same edge. The other source's flag is left unchanged.
- R7: While the master enable is 0, flags still latch and no call is issued.
- R8: While `stack_full` is 1, no call is issued even for a pending, enabled source. Service resumes on the edge after `stack_full` returns to 0.
- R9: When both sources are pending and enabled in the same cycle, the external source is served first.
- R10: If software sets the master enable again while a flag is still pending, that source is served. This covers nesting inside a service routine.
- R11: A hardware flag set (pin edge or timer strobe) in the same cycle as a software write of 0 to that flag, or as acceptance of that source, leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| int_n | input | 1 | External interrupt pin, falling-edge sensitive |
| tmr_ovf | input | 1 | Timer 0 overflow strobe |
| stack_full | input | 1 | Core return stack is full |
| call_req | output | 1 | One-cycle vectored call request |
| call_vec | output | 8 | Vector address of the call |
| call_src | output | 2 | One-hot accepted source (bit 0 external, bit 1 timer) |

## Verification
The embedded assertions check the following on every cycle:
- no call follows a cycle with a full stack or with the master enable off;
- the vector always matches the one-hot source;
- the master enable is always clear after a call;
- the external source wins when both sources are eligible;
- a synchronized pin edge always leaves the external flag set.

Only the bench scenarios can show the rest: the exact three-edge latency of the pin, the register map and its ignored bits and addresses, resumption once the stack empties, re-enabling for nesting, and a hardware set winning over a software clear. The scoreboard catches any extra call and any call that is missing.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int              AW          = 8,
  parameter logic [AW-1:0]   CTRL_ADDR   = 8'h0B,
  parameter logic [7:0]      EXT_VEC     = 8'h04,
  parameter logic [7:0]      TMR_VEC     = 8'h08,
  parameter int              SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          int_n,
  input  logic          tmr_ovf,
  input  logic          stack_full,
  output logic          call_req,
  output logic [7:0]    call_vec,
  output logic [1:0]    call_src
);

  localparam int PIN_W = SYNC_STAGES + 1;

  logic [PIN_W-1:0] pin_q;
  logic             emi, ext_en, tmr_en, ext_flag, tmr_flag;
  logic             hit, wr, pin_fall, ext_take, tmr_take, take;

  assign hit      = (reg_addr == CTRL_ADDR);
  assign wr       = reg_we && hit;
  assign pin_fall = pin_q[PIN_W-1] & ~pin_q[PIN_W-2];

  assign ext_take = emi & ~stack_full & ext_en & ext_flag;
  assign tmr_take = emi & ~stack_full & tmr_en & tmr_flag & ~ext_take;
  assign take     = ext_take | tmr_take;

  assign reg_rdata = hit ? {2'b00, tmr_flag, ext_flag, 1'b0, tmr_en, ext_en, emi} : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '1;
    else        pin_q <= {pin_q[PIN_W-2:0], int_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emi      <= 1'b0;
      ext_en   <= 1'b0;
      tmr_en   <= 1'b0;
      ext_flag <= 1'b0;
      tmr_flag <= 1'b0;
    end else begin
      if (wr) begin
        ext_en <= reg_wdata[1];
        tmr_en <= reg_wdata[2];
      end
      emi      <= take ? 1'b0 : (wr ? reg_wdata[0] : emi);
      ext_flag <= pin_fall | (ext_take ? 1'b0 : (wr ? reg_wdata[4] : ext_flag));
      tmr_flag <= tmr_ovf  | (tmr_take ? 1'b0 : (wr ? reg_wdata[5] : tmr_flag));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req <= 1'b0;
      call_vec <= 8'h00;
      call_src <= 2'b00;
    end else begin
      call_req <= take;
      call_vec <= ext_take ? EXT_VEC : (tmr_take ? TMR_VEC : 8'h00);
      call_src <= {tmr_take, ext_take};
    end
  end

  AST_NO_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(stack_full)); // R8
  AST_NO_CALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(emi) |-> !call_req); // R7
  AST_EMI_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !emi); // R6
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(call_src) && (call_req == (call_src != 2'b00))); // R5
  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == (call_src[0] ? EXT_VEC : TMR_VEC))); // R5
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(emi && !stack_full && ext_en && ext_flag && tmr_en && tmr_flag) |-> call_src == 2'b01); // R9
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_fall) |-> ext_flag); // R3

endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0, int_n = 1, tmr_ovf = 0, stack_full = 0;
  logic [7:0] reg_addr = 8'h0B, reg_wdata = 0, reg_rdata, call_vec;
  logic [1:0] call_src;
  logic       call_req;
  int         checks = 0, errors = 0;
  bit         done = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (.*);

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 8'h0B;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(tag, {2'b00, reg_rdata}, {2'b00, exp});
    reg_addr = 8'h0B;
  endtask

  task automatic expect_call(input string tag, input logic [1:0] src, input logic [7:0] vec);
    exp_q.push_back({src, vec});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && call_req && !done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual unexpected call %h/%h expected none", call_src, call_vec);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {call_src, call_vec}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(1);
    rd("R1 reset reg", 8'h0B, 8'h00);
    chk("R1 reset call", {call_src, call_vec}, 10'h000);
    chk("R1 reset req", {9'd0, call_req}, 10'd0);

    wr(8'h0B, 8'hF8);
    rd("R2 reserved bits", 8'h0B, 8'h30);
    wr(8'h0B, 8'h00);
    wr(8'h0C, 8'h37);
    rd("R2 other addr write ignored", 8'h0B, 8'h00);
    rd("R2 other addr reads zero", 8'h0C, 8'h00);

    int_n = 0;
    cyc(2);
    rd("R3 not yet after two edges", 8'h0B, 8'h00);
    cyc(1);
    rd("R3 flag after third edge", 8'h0B, 8'h10);
    wr(8'h0B, 8'h00);
    int_n = 1;
    cyc(5);
    rd("R3 rising edge ignored", 8'h0B, 8'h00);

    tmr_ovf = 1; cyc(1); tmr_ovf = 0;
    rd("R4 timer flag", 8'h0B, 8'h20);
    wr(8'h0B, 8'h06);

    tmr_ovf = 1; cyc(1); tmr_ovf = 0;
    int_n = 0; cyc(4); int_n = 1;
    cyc(3);
    rd("R7 flags latch while masked", 8'h0B, 8'h36);

    expect_call("R9 ext first", 2'b01, 8'h04);
    wr(8'h0B, 8'h37);
    cyc(3);
    rd("R6 emi and ext flag cleared", 8'h0B, 8'h26);

    expect_call("R10 re-enable serves timer", 2'b10, 8'h08);
    wr(8'h0B, 8'h27);
    cyc(3);
    rd("R6 timer flag cleared", 8'h0B, 8'h06);

    stack_full = 1;
    wr(8'h0B, 8'h25);
    cyc(5);
    rd("R8 held while stack full", 8'h0B, 8'h25);
    expect_call("R8 resume", 2'b10, 8'h08);
    stack_full = 0;
    cyc(3);
    rd("R8 serviced after resume", 8'h0B, 8'h04);

    reg_we = 1; reg_addr = 8'h0B; reg_wdata = 8'h00; tmr_ovf = 1;
    cyc(1);
    reg_we = 0; tmr_ovf = 0;
    rd("R11 hw set beats sw clear", 8'h0B, 8'h20);

    wr(8'h0B, 8'h25);
    tmr_ovf = 1;
    expect_call("R11 accept call", 2'b10, 8'h08);
    cyc(1);
    tmr_ovf = 0;
    cyc(2);
    rd("R11 hw set beats accept clear", 8'h0B, 8'h24);
    wr(8'h0B, 8'h00);

    cyc(4);
    chk("R5 all expected calls seen", exp_q.size(), 10'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule